// File: doc/BRIEF.md
# Ratio-Weighted Two-Input Output Arbiter

This block arbitrates one output port of a tree switch in a packet network on chip. Exactly two inputs can ask for the output. The favoured input is fixed at design time: it is the input that carries the larger share of traffic. The other input is protected from starvation by a credit counter. Each contended win by the favoured input uses up one credit. When no credit is left, the next contended arbitration goes to the other input. When that packet ends, the credit counter is refilled.

The credit refill value is derived from two design-time weights. These are the traffic shares of the favoured input and of the other input, given as integers. The refill value is the ceiling of their quotient. A grant is registered and one-hot. It stays on until the packet-done pulse for that packet arrives. Between packets the grant spends one cycle idle before the next arbitration.

Top module: `ratio_arb2`

## Requirements
- R1: After reset no grant is driven (`gnt_o` = 2'b00) and the credit counter holds the refill value.
- R2: The refill value is ceil(HI_WEIGHT / LO_WEIGHT), which is at least 1. With the defaults 3 and 2 it is 2.
- R3: While idle, if only one input requests, that input is granted on the next clock and the credit count is unchanged.
- R4: While idle, if both inputs request and credit is above zero, the favoured input (`gnt_o[0]`) is granted on the next clock and the credit drops by one.
- R5: While idle, if both inputs request and credit is zero, the other input (`gnt_o[1]`) is granted on the next clock. Credit never goes below zero.
- R6: When a packet from the other input that was granted under contention completes, the credit reloads to the refill value.
- R7: Completion of an uncontended grant to the other input leaves the credit unchanged.
- R8: A grant is held unchanged, whatever the requests, until `pkt_done_i` is seen high.
- R9: `gnt_o` is one-hot or zero. Bit 0 means the favoured input and bit 1 means the other input. A grant only goes to an input that requested in the arbitration cycle.
- R10: The grant clears on the clock after `pkt_done_i`. The next arbitration happens in the following cycle. `pkt_done_i` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_hi_i | input | 1 | Request from the favoured input |
| req_lo_i | input | 1 | Request from the other input |
| pkt_done_i | input | 1 | Last flit of the granted packet leaves this cycle |
| gnt_o | output | 2 | One-hot grant: bit 0 favoured, bit 1 other |

## Verification
Two events can fall in the same cycle. A packet can end at the very moment the other input is still requesting. A contended arbitration can also meet an exhausted credit at the same time as a refill would be pending. The bench provokes these cases by keeping both requests high across `pkt_done_i` pulses. This forces each grant handover to coincide with a credit decrement or a credit reload. A behavioural model tracks the grant owner and the credit as plain integers, and the bench compares the grant with that model on every clock. Separate runs check three more things: a single low-priority packet must not refill the credit, requests that change in the middle of a packet must not move the grant, and a done pulse while idle must be ignored.

// File: rtl/ratio_arb2_pkg.sv
package ratio_arb2_pkg;
    typedef struct packed {
        logic [1:0] gnt;      // bit0 favoured, bit1 other
        logic       lo_cont;  // other input won under contention
    } own_state_t;

    function automatic int unsigned refill_of(input int unsigned hi_w, input int unsigned lo_w);
        int unsigned r;
        r = (hi_w + lo_w - 1) / lo_w;
        return (r < 1) ? 1 : r;
    endfunction
endpackage

// File: rtl/ratio_arb2_pick.sv
module ratio_arb2_pick (
    input  logic       req_hi_i,
    input  logic       req_lo_i,
    input  logic       credit_zero_i,
    output logic [1:0] pick_o,
    output logic       contended_o
);
    always_comb begin
        contended_o = req_hi_i & req_lo_i;
        pick_o      = 2'b00;
        if (contended_o) begin
            pick_o = credit_zero_i ? 2'b10 : 2'b01;
        end else if (req_hi_i) begin
            pick_o = 2'b01;
        end else if (req_lo_i) begin
            pick_o = 2'b10;
        end
    end

    always_comb begin
        assert_pick_onehot_R9: assert ($onehot0(pick_o));
    end
endmodule

// File: rtl/ratio_arb2_credit.sv
module ratio_arb2_credit #(
    parameter int unsigned REFILL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_i,
    input  logic reload_i,
    output logic zero_o
);
    localparam int unsigned CW = $clog2(REFILL + 1);
    localparam logic [CW-1:0] REFILL_C = CW'(REFILL);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload_i) begin
            cnt_d = REFILL_C;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= REFILL_C;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    assert_credit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= REFILL_C);
    assert_credit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !reload_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_credit_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cnt_q == REFILL_C));
    assert_credit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ratio_arb2.sv
module ratio_arb2
    import ratio_arb2_pkg::*;
#(
    parameter int unsigned HI_WEIGHT = 3,
    parameter int unsigned LO_WEIGHT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_hi_i,
    input  logic       req_lo_i,
    input  logic       pkt_done_i,
    output logic [1:0] gnt_o
);
    localparam int unsigned REFILL = refill_of(HI_WEIGHT, LO_WEIGHT);

    own_state_t st_d, st_q;
    logic [1:0] pick;
    logic       contended, credit_zero, idle, dec, reload;

    ratio_arb2_pick u_pick (
        .req_hi_i      (req_hi_i),
        .req_lo_i      (req_lo_i),
        .credit_zero_i (credit_zero),
        .pick_o        (pick),
        .contended_o   (contended)
    );

    ratio_arb2_credit #(.REFILL(REFILL)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_i    (dec),
        .reload_i (reload),
        .zero_o   (credit_zero)
    );

    assign idle = (st_q.gnt == 2'b00);

    always_comb begin
        st_d   = st_q;
        dec    = 1'b0;
        reload = 1'b0;
        if (idle) begin
            st_d.gnt     = pick;
            st_d.lo_cont = contended & pick[1];
            dec          = contended & pick[0];
        end else if (pkt_done_i) begin
            st_d.gnt     = 2'b00;
            st_d.lo_cont = 1'b0;
            reload       = st_q.gnt[1] & st_q.lo_cont;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_o = st_q.gnt;

    assert_gnt_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    assert_gnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !pkt_done_i) |=> $stable(gnt_o));
    assert_gnt_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && pkt_done_i) |=> (gnt_o == 2'b00));
    assert_single_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_hi_i && !req_lo_i) |=> (gnt_o == 2'b01));
    assert_single_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !req_hi_i && req_lo_i) |=> (gnt_o == 2'b10));
    assert_starved_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_hi_i && req_lo_i && credit_zero) |=> (gnt_o == 2'b10));
    assert_fav_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_hi_i && req_lo_i && !credit_zero) |=> (gnt_o == 2'b01));
    assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !req_hi_i && !req_lo_i) |=> (gnt_o == 2'b00));
endmodule

// File: tb/test_ratio_arb2.sv
module test_ratio_arb2;
    localparam int HI_W = 3;
    localparam int LO_W = 2;
    localparam int REFILL = (HI_W + LO_W - 1) / LO_W; // R2: expect 2

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_hi = 1'b0, req_lo = 1'b0, done = 1'b0;
    logic [1:0] gnt;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int m_gnt = 0;      // 0 none, 1 favoured, 2 other
    int m_credit = REFILL;
    bit m_lo_cont = 0;

    always #5 clk = ~clk;

    ratio_arb2 #(.HI_WEIGHT(HI_W), .LO_WEIGHT(LO_W)) i_ratio_arb2 (
        .clk(clk), .rst_n(rst_n), .req_hi_i(req_hi), .req_lo_i(req_lo),
        .pkt_done_i(done), .gnt_o(gnt)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gnt actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic h, input logic l, input logic d, input string tag);
        @(negedge clk);
        req_hi = h; req_lo = l; done = d;
        @(posedge clk);
        #1;
        if (m_gnt != 0) begin
            if (d) begin
                if (m_gnt == 2 && m_lo_cont) m_credit = REFILL;
                m_gnt = 0;
                m_lo_cont = 0;
            end
        end else if (h && l) begin
            if (m_credit == 0) begin m_gnt = 2; m_lo_cont = 1; end
            else begin m_gnt = 1; m_credit = m_credit - 1; end
        end else if (h) begin
            m_gnt = 1;
        end else if (l) begin
            m_gnt = 2; m_lo_cont = 0;
        end
        check(tag, gnt, {m_gnt == 2, m_gnt == 1});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", gnt, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: single favoured request, then done
        step(1, 0, 0, "R3 single hi");
        step(0, 0, 0, "R8 hold hi");
        step(0, 0, 1, "R10 release");
        step(0, 0, 0, "R10 idle");
        // R3: single other request
        step(0, 1, 0, "R3 single lo");
        step(0, 0, 1, "R10 release lo");
        // R10: done while idle ignored
        step(0, 0, 1, "R10 done idle");
        step(0, 0, 0, "R10 still idle");

        // R4/R5/R6: continuous contention with done pulses
        for (int k = 0; k < 9; k++) begin
            step(1, 1, 0, "R4 R5 contend grant");
            step(1, 1, 0, "R8 contend hold");
            step(1, 1, 1, "R6 contend done");
        end

        // R7: exhaust credit, then uncontended other packet must not refill
        step(0, 0, 0, "R7 idle");
        step(1, 1, 0, "R4 drain");
        step(0, 0, 1, "R10 drain done");
        step(1, 1, 0, "R4 drain2");
        step(0, 0, 1, "R10 drain2 done");
        step(1, 1, 0, "R5 zero credit win");
        step(0, 0, 1, "R6 refill done");
        step(1, 1, 0, "R4 after refill");
        step(0, 0, 1, "R10 done");
        step(1, 1, 0, "R4 after refill 2");
        step(0, 0, 1, "R10 done");
        step(0, 1, 0, "R7 lone lo");
        step(1, 0, 0, "R8 hold vs hi");
        step(0, 1, 1, "R7 lone lo done");
        step(1, 1, 0, "R7 credit still zero");
        step(0, 0, 1, "R10 done");

        // R8/R9: requests toggle mid-packet
        step(1, 0, 0, "R9 grant requester");
        step(0, 1, 0, "R8 hold change");
        step(1, 1, 0, "R8 hold both");
        step(0, 0, 0, "R8 hold none");
        step(0, 0, 1, "R10 done");
        step(0, 0, 0, "R9 no req no grant");

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule